// File: doc/BRIEF.md
# Chained Page-Bounded DMA Engine

This block copies data between a device port and a memory port with no processor on the data path. Software loads a memory base address, a byte count and a direction into a small register file and writes a start bit. The engine then asks a shared-bus arbiter for the bus. It moves words only while it holds the grant and the device signals ready. Data moves in bursts of up to `BURST_WORDS` back-to-back words. After the last word of each burst the engine lets go of the bus.

Larger moves are split into links of at most one 4 KiB page. Each link is a descriptor held in memory and read through a descriptor port. A descriptor carries a base, a byte count, a direction, a final-link flag and the address of the next descriptor. The engine walks the list and raises one level interrupt, either after the final link or when a link is invalid. Software can use that interrupt, or it can poll the status register. It clears the interrupt by writing 1 to the status bits.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, the status register (offset 4) reads zero, `irq` is low, `bus_req` is low and no memory beat occurs.
- R2: A single transfer with control bit1 = 0 (device to memory) writes `bytes/4` words. They go to consecutive word addresses from the base (offset 1) and carry the device words in arrival order, with `mem_we` high.
- R3: A single transfer with control bit1 = 1 (memory to device) reads the same address run with `mem_we` low and passes each memory word unchanged to `dev_wdata`.
- R4: A beat (`mem_valid`, equal to `dev_strobe`) occurs only while `bus_req`, `bus_gnt` and `dev_ready` are all high. A low `dev_ready` stalls the burst without losing or repeating a word.
- R5: A burst has between 1 and `BURST_WORDS` beats. `bus_req` stays high from request until the final beat, then falls in the same cycle as a one-cycle `bus_done` pulse.
- R6: A byte count of zero, a count or base that is not a multiple of 4, or a base plus count that runs past the end of its 4 KiB page sets status error (bit2) and raises `irq` with no beat. A run that ends exactly on the page end is valid.
- R7: With control bit2 = 1, the engine fetches descriptors starting at the link pointer (offset 3) and performs each one in list order. The descriptor is packed {next[78:47], base[46:15], bytes[14:2], to_dev[1], final[0]}. `irq` rises exactly once, after the link whose final bit is 1, and status done (bit1) is set.
- R8: An invalid descriptor in a chain ends the chain with status error set and done clear. It causes no beat and no further descriptor fetch.
- R9: Status bit0 reads 1 while a transfer is in progress. `irq` is a level that stays high until software writes 1 to status bit1 or bit2; writing 0 there leaves it set.
- R10: While busy, a start write and writes to control, base, count and link pointer are ignored: no extra beats occur and the registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt: done or error pending |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_done | output | 1 | One-cycle pulse after the last word of a burst |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 32 | Descriptor address (link pointer) |
| desc_valid | input | 1 | Descriptor data valid |
| desc_data | input | 79 | Packed descriptor |
| mem_valid | output | 1 | Memory beat this cycle |
| mem_we | output | 1 | 1 = write memory, 0 = read memory |
| mem_addr | output | 32 | Memory byte address of the beat |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (same cycle) |
| dev_ready | input | 1 | Device can take or give a word |
| dev_strobe | output | 1 | Device word consumed or produced |
| dev_dir | output | 1 | 1 = data flows to the device |
| dev_rdata | input | 32 | Word from the device |
| dev_wdata | output | 32 | Word to the device |

## Verification
The bench targets the burst split at the remainder (10 words into bursts of 4, 4 and 2). A design that gets this wrong either runs past the count or drops the tail. It tests a run that ends exactly on the page end against one that runs 4 bytes over. An off-by-one in the page test would reject the first or accept the second. It runs a three-link chain with mixed directions and checks that the interrupt rises once at the end and not after each link. It also checks that an invalid second link stops the list before any of its beats. Device stalls and start or register writes made in the middle of a transfer are applied as well. A design that handled them wrongly would repeat or skip words, start a second run, or change its base part way through.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int CNT_W     = PAGE_BITS + 1;
  localparam int WCNT_W    = CNT_W - 2;
  localparam int REG_AW    = 3;

  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_REQ_BUS   = 3'd1,
    S_XFER      = 3'd2,
    S_RELEASE   = 3'd3,
    S_NEXT_DESC = 3'd4,
    S_DONE      = 3'd5
  } dma_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] next_ptr;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  bytes;
    logic              to_dev;
    logic              final_link;
  } dma_desc_t;

  localparam int DESC_W = $bits(dma_desc_t);

  // A segment is rejected when empty, misaligned or spilling past its page.
  function automatic logic seg_invalid(input logic [PAGE_BITS-1:0] offs,
                                       input logic [CNT_W-1:0] n);
    logic [CNT_W:0] span;
    span = {2'b00, offs} + {1'b0, n};
    return (n == '0) || (n[1:0] != 2'b00) || (offs[1:0] != 2'b00) ||
           (span > (CNT_W+1)'(1 << PAGE_BITS));
  endfunction

  // Beats in the next burst: the remainder, capped at the burst size.
  function automatic logic [WCNT_W-1:0] beats_for(input logic [WCNT_W-1:0] left,
                                                  input logic [WCNT_W-1:0] cap);
    return (left > cap) ? cap : left;
  endfunction
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              seq_busy,
  input  logic              set_done,
  input  logic              set_err,
  input  logic              link_load,
  input  logic [ADDR_W-1:0] link_value,
  output logic              go,
  output logic              cfg_to_dev,
  output logic              cfg_chain,
  output logic [ADDR_W-1:0] cfg_base,
  output logic [CNT_W-1:0]  cfg_bytes,
  output logic [ADDR_W-1:0] link_ptr,
  output logic              irq
);
  localparam logic [REG_AW-1:0] OFS_CTRL   = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_BASE   = REG_AW'(1);
  localparam logic [REG_AW-1:0] OFS_BYTES  = REG_AW'(2);
  localparam logic [REG_AW-1:0] OFS_LINK   = REG_AW'(3);
  localparam logic [REG_AW-1:0] OFS_STATUS = REG_AW'(4);

  logic go_q, done_q, err_q, busy_all, cfg_wr_ok, status_wr, start_wr;

  assign busy_all  = seq_busy | go_q;
  assign cfg_wr_ok = reg_we & ~busy_all;
  assign status_wr = reg_we & (reg_addr == OFS_STATUS);
  assign start_wr  = cfg_wr_ok & (reg_addr == OFS_CTRL) & reg_wdata[0];
  assign go        = go_q;
  assign irq       = done_q | err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q       <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      cfg_to_dev <= 1'b0;
      cfg_chain  <= 1'b0;
      cfg_base   <= '0;
      cfg_bytes  <= '0;
      link_ptr   <= '0;
    end else begin
      go_q   <= start_wr;
      done_q <= set_done | (done_q & ~(status_wr & reg_wdata[1]));
      err_q  <= set_err  | (err_q  & ~(status_wr & reg_wdata[2]));
      if (link_load) begin
        link_ptr <= link_value;
      end else if (cfg_wr_ok) begin
        case (reg_addr)
          OFS_CTRL: begin
            cfg_to_dev <= reg_wdata[1];
            cfg_chain  <= reg_wdata[2];
          end
          OFS_BASE:  cfg_base  <= reg_wdata;
          OFS_BYTES: cfg_bytes <= reg_wdata[CNT_W-1:0];
          OFS_LINK:  link_ptr  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:   reg_rdata = {{(DATA_W-3){1'b0}}, cfg_chain, cfg_to_dev, 1'b0};
      OFS_BASE:   reg_rdata = cfg_base;
      OFS_BYTES:  reg_rdata = {{(DATA_W-CNT_W){1'b0}}, cfg_bytes};
      OFS_LINK:   reg_rdata = link_ptr;
      OFS_STATUS: reg_rdata = {{(DATA_W-3){1'b0}}, err_q, done_q, busy_all};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_xfer_path.sv
module dma_xfer_path
  import dma_chain_pkg::*;
#(
  parameter int unsigned BURST_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cfg,
  input  logic              load_desc,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [WCNT_W-1:0] cfg_words,
  input  logic              cfg_to_dev,
  input  logic [ADDR_W-1:0] dsc_base,
  input  logic [WCNT_W-1:0] dsc_words,
  input  logic              dsc_to_dev,
  input  logic              burst_begin,
  input  logic              beat,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              to_dev,
  output logic              burst_last,
  output logic              words_zero
);
  localparam logic [WCNT_W-1:0] CAP      = WCNT_W'(BURST_WORDS);
  localparam logic [ADDR_W-1:0] WORD_INC = ADDR_W'(DATA_W / 8);

  logic [WCNT_W-1:0] left_q, run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left_q   <= '0;
      run_q    <= '0;
      to_dev   <= 1'b0;
    end else begin
      if (load_cfg) begin
        cur_addr <= cfg_base;
        left_q   <= cfg_words;
        to_dev   <= cfg_to_dev;
      end else if (load_desc) begin
        cur_addr <= dsc_base;
        left_q   <= dsc_words;
        to_dev   <= dsc_to_dev;
      end else if (beat) begin
        cur_addr <= cur_addr + WORD_INC;
        left_q   <= left_q - 1'b1;
      end
      if (burst_begin) begin
        run_q <= beats_for(left_q, CAP);
      end else if (beat) begin
        run_q <= run_q - 1'b1;
      end
    end
  end

  assign burst_last = (run_q == WCNT_W'(1));
  assign words_zero = (left_q == '0);
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       cfg_chain,
  input  logic       cfg_bad,
  input  logic       desc_valid,
  input  logic       desc_bad,
  input  logic       desc_final,
  input  logic       bus_gnt,
  input  logic       dev_ready,
  input  logic       burst_last,
  input  logic       words_zero,
  output dma_state_t state,
  output logic       beat,
  output logic       bus_req,
  output logic       bus_done,
  output logic       desc_req,
  output logic       load_cfg,
  output logic       load_desc,
  output logic       burst_begin,
  output logic       set_done,
  output logic       set_err
);
  dma_state_t nxt;
  logic fail_q, last_q, fail_now;

  always_comb begin
    nxt         = state;
    beat        = 1'b0;
    bus_req     = 1'b0;
    bus_done    = 1'b0;
    desc_req    = 1'b0;
    load_cfg    = 1'b0;
    load_desc   = 1'b0;
    burst_begin = 1'b0;
    set_done    = 1'b0;
    set_err     = 1'b0;
    fail_now    = 1'b0;
    case (state)
      S_IDLE: begin
        if (go) begin
          if (cfg_chain) begin
            nxt = S_NEXT_DESC;
          end else if (cfg_bad) begin
            fail_now = 1'b1;
            nxt      = S_DONE;
          end else begin
            load_cfg = 1'b1;
            nxt      = S_REQ_BUS;
          end
        end
      end
      S_NEXT_DESC: begin
        desc_req = 1'b1;
        if (desc_valid) begin
          if (desc_bad) begin
            fail_now = 1'b1;
            nxt      = S_DONE;
          end else begin
            load_desc = 1'b1;
            nxt       = S_REQ_BUS;
          end
        end
      end
      S_REQ_BUS: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          burst_begin = 1'b1;
          nxt         = S_XFER;
        end
      end
      S_XFER: begin
        bus_req = 1'b1;
        beat    = dev_ready;
        if (dev_ready && burst_last) nxt = S_RELEASE;
      end
      S_RELEASE: begin
        bus_done = 1'b1;
        if (!words_zero)  nxt = S_REQ_BUS;
        else if (!last_q) nxt = S_NEXT_DESC;
        else              nxt = S_DONE;
      end
      S_DONE: begin
        set_err  = fail_q;
        set_done = ~fail_q;
        nxt      = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fail_q <= 1'b0;
      last_q <= 1'b1;
    end else begin
      state <= nxt;
      if (state == S_IDLE && go) fail_q <= 1'b0;
      if (fail_now)              fail_q <= 1'b1;
      if (load_cfg)              last_q <= 1'b1;
      else if (load_desc)        last_q <= desc_final;
    end
  end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int unsigned BURST_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_done,
  output logic              desc_req,
  output logic [ADDR_W-1:0] desc_addr,
  input  logic              desc_valid,
  input  logic [DESC_W-1:0] desc_data,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_ready,
  output logic              dev_strobe,
  output logic              dev_dir,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata
);
  // Named internal events, visible to the bound checker.
  dma_state_t        seq_state;
  logic              go, cfg_to_dev, cfg_chain, cfg_bad, dsc_bad;
  logic [ADDR_W-1:0] cfg_base, link_ptr, cur_addr;
  logic [CNT_W-1:0]  cfg_bytes;
  logic              beat, load_cfg, load_desc, burst_begin;
  logic              set_done, set_err, burst_last, words_zero, to_dev;
  dma_desc_t         dsc;

  assign dsc     = desc_data;
  assign cfg_bad = seg_invalid(cfg_base[PAGE_BITS-1:0], cfg_bytes);
  assign dsc_bad = seg_invalid(dsc.base[PAGE_BITS-1:0], dsc.bytes);

  dma_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .seq_busy   (seq_state != S_IDLE),
    .set_done   (set_done),
    .set_err    (set_err),
    .link_load  (load_desc & ~dsc.final_link),
    .link_value (dsc.next_ptr),
    .go         (go),
    .cfg_to_dev (cfg_to_dev),
    .cfg_chain  (cfg_chain),
    .cfg_base   (cfg_base),
    .cfg_bytes  (cfg_bytes),
    .link_ptr   (link_ptr),
    .irq        (irq)
  );

  dma_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .cfg_chain   (cfg_chain),
    .cfg_bad     (cfg_bad),
    .desc_valid  (desc_valid),
    .desc_bad    (dsc_bad),
    .desc_final  (dsc.final_link),
    .bus_gnt     (bus_gnt),
    .dev_ready   (dev_ready),
    .burst_last  (burst_last),
    .words_zero  (words_zero),
    .state       (seq_state),
    .beat        (beat),
    .bus_req     (bus_req),
    .bus_done    (bus_done),
    .desc_req    (desc_req),
    .load_cfg    (load_cfg),
    .load_desc   (load_desc),
    .burst_begin (burst_begin),
    .set_done    (set_done),
    .set_err     (set_err)
  );

  dma_xfer_path #(.BURST_WORDS(BURST_WORDS)) u_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_cfg    (load_cfg),
    .load_desc   (load_desc),
    .cfg_base    (cfg_base),
    .cfg_words   (cfg_bytes[CNT_W-1:2]),
    .cfg_to_dev  (cfg_to_dev),
    .dsc_base    (dsc.base),
    .dsc_words   (dsc.bytes[CNT_W-1:2]),
    .dsc_to_dev  (dsc.to_dev),
    .burst_begin (burst_begin),
    .beat        (beat),
    .cur_addr    (cur_addr),
    .to_dev      (to_dev),
    .burst_last  (burst_last),
    .words_zero  (words_zero)
  );

  assign desc_addr  = link_ptr;
  assign mem_valid  = beat;
  assign mem_we     = ~to_dev;
  assign mem_addr   = cur_addr;
  assign mem_wdata  = dev_rdata;
  assign dev_wdata  = mem_rdata;
  assign dev_strobe = beat;
  assign dev_dir    = to_dev;
endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker
  import dma_chain_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_done,
  input logic              desc_req,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dev_ready,
  input logic              irq,
  input logic              status_wr,
  input logic [1:0]        clr_bits,
  input dma_state_t        seq_state
);
  assert_beat_under_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (bus_req && bus_gnt && dev_ready));

  assert_release_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> bus_done);

  assert_done_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> !bus_done);

  assert_run_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid)) |->
      (mem_addr == $past(mem_addr) + ADDR_W'(4)) &&
      (mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS])));

  assert_fetch_off_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req |-> !bus_req);

  assert_irq_after_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (seq_state == S_IDLE));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(status_wr && (clr_bits != 2'b00))) |=> irq);
endmodule

bind dma_chain_engine dma_chain_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_done  (bus_done),
  .desc_req  (desc_req),
  .mem_valid (mem_valid),
  .mem_addr  (mem_addr),
  .dev_ready (dev_ready),
  .irq       (irq),
  .status_wr (reg_we && (reg_addr == 3'd4)),
  .clr_bits  (reg_wdata[2:1]),
  .seq_state (seq_state)
);

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;
  import dma_chain_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BURST      = 4;
  localparam int WATCHDOG   = 20000;
  localparam logic [31:0] DEV_BASE = 32'hD000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, bus_req, bus_done, desc_req, mem_valid, mem_we, dev_strobe, dev_dir;
  logic bus_gnt = 1'b0;
  logic desc_valid = 1'b0;
  logic dev_ready = 1'b1;
  logic [31:0] desc_addr, mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;
  logic [DESC_W-1:0] desc_data;
  logic [31:0] dev_cnt = '0;
  logic [2:0]  stall_ctr = '0;
  logic        stall_mode = 1'b0;
  dma_desc_t   desc_tab [8];

  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; } beat_t;
  beat_t sb[$];

  int tests = 0, fails = 0;
  int exp_dev = 0, bursts_seen = 0, run_beats = 0, irq_rises = 0, fetches = 0;
  logic prev_irq = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  assign mem_rdata = pat(mem_addr);
  assign dev_rdata = DEV_BASE + dev_cnt;
  assign desc_data = desc_tab[desc_addr[6:4]];

  // Environment: arbiter, device, descriptor memory (registered responses).
  always @(posedge clk) begin
    bus_gnt    <= bus_req;
    desc_valid <= desc_req && !desc_valid;
    stall_ctr  <= stall_ctr + 3'd1;
    dev_ready  <= stall_mode ? (stall_ctr[1] | stall_ctr[0]) : 1'b1;
    if (dev_strobe && !dev_dir) dev_cnt <= dev_cnt + 32'd1;
  end

  dma_chain_engine #(.BURST_WORDS(BURST)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_done(bus_done),
    .desc_req(desc_req), .desc_addr(desc_addr), .desc_valid(desc_valid),
    .desc_data(desc_data), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_ready(dev_ready), .dev_strobe(dev_strobe), .dev_dir(dev_dir),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected beats of one segment.
  task automatic push_seg(input logic [31:0] base, input int bytes, input bit to_dev);
    for (int i = 0; i < bytes / 4; i++) begin
      beat_t b;
      b.addr = base + 32'(4 * i);
      b.we   = !to_dev;
      if (to_dev) b.data = pat(b.addr);
      else begin
        b.data = DEV_BASE + 32'(exp_dev);
        exp_dev++;
      end
      sb.push_back(b);
    end
  endtask

  // Monitor side: pops and compares every beat; also tracks bursts, irq, fetches.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid) begin
        run_beats++;
        check(bus_gnt && bus_req && dev_ready && dev_strobe, "R4 beat qualifiers",
              {28'd0, bus_gnt, bus_req, dev_ready, dev_strobe}, 32'hF);
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected beat", mem_addr, 32'hFFFF_FFFF);
        end else begin
          beat_t e;
          e = sb.pop_front();
          check(mem_addr == e.addr, "R2/R3 beat address", mem_addr, e.addr);
          check(mem_we == e.we, "R2/R3 beat direction", {31'd0, mem_we}, {31'd0, e.we});
          if (e.we) check(mem_wdata == e.data, "R2 memory write data", mem_wdata, e.data);
          else      check(dev_wdata == e.data, "R3 device data", dev_wdata, e.data);
        end
      end
      if (bus_done) begin
        check(run_beats >= 1 && run_beats <= BURST, "R5 burst length",
              32'(run_beats), 32'(BURST));
        check(!bus_req, "R5 request dropped with done", {31'd0, bus_req}, 32'd0);
        bursts_seen++;
        run_beats = 0;
      end
      if (irq && !prev_irq) irq_rises++;
      prev_irq = irq;
      if (desc_valid && desc_req) fetches++;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(irq, tag, {31'd0, irq}, 32'd1);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_single(input logic [31:0] base, input int bytes, input bit to_dev);
    reg_write(3'd4, 32'h6);
    reg_write(3'd1, base);
    reg_write(3'd2, 32'(bytes));
    reg_write(3'd0, {29'd0, 1'b0, to_dev, 1'b1});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1-all actual=%h expected=%h", 32'(WATCHDOG), 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int b0, f0, i0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    reg_read(3'd4, v);
    check(v == 32'd0, "R1 status after reset", v, 32'd0);
    check(!irq && !bus_req && !mem_valid, "R1 outputs idle",
          {29'd0, irq, bus_req, mem_valid}, 32'd0);

    // R2/R5: device to memory, 10 words -> bursts of 4,4,2
    b0 = bursts_seen;
    push_seg(32'h100, 40, 1'b0);
    run_single(32'h100, 40, 1'b0);
    wait_irq("R2 irq after single transfer");
    check(sb.size() == 0, "R2 all beats seen", 32'(sb.size()), 32'd0);
    check(bursts_seen - b0 == 3, "R5 burst split", 32'(bursts_seen - b0), 32'd3);
    reg_read(3'd4, v);
    check(v == 32'h2, "R9 status done, not busy", v, 32'h2);
    // R9: level interrupt, W1C
    reg_write(3'd4, 32'h0);
    check(irq, "R9 write 0 keeps irq", {31'd0, irq}, 32'd1);
    reg_write(3'd4, 32'h2);
    check(!irq, "R9 write 1 clears irq", {31'd0, irq}, 32'd0);

    // R3/R4: memory to device with device stalls
    stall_mode = 1'b1;
    push_seg(32'h800, 24, 1'b1);
    run_single(32'h800, 24, 1'b1);
    wait_irq("R3 irq after read transfer");
    check(sb.size() == 0, "R4 stalled run complete", 32'(sb.size()), 32'd0);
    stall_mode = 1'b0;

    // R6: exactly ending on page end is valid
    push_seg(32'hFF0, 16, 1'b0);
    run_single(32'hFF0, 16, 1'b0);
    wait_irq("R6 page-end run irq");
    reg_read(3'd4, v);
    check(v == 32'h2 && sb.size() == 0, "R6 page-end run accepted", v, 32'h2);

    // R6: crossing, zero and misaligned segments
    b0 = bursts_seen;
    run_single(32'hFF0, 20, 1'b0);
    wait_irq("R6 cross irq");
    reg_read(3'd4, v);
    check(v == 32'h4, "R6 page cross error", v, 32'h4);
    run_single(32'h040, 0, 1'b0);
    wait_irq("R6 zero irq");
    reg_read(3'd4, v);
    check(v == 32'h4, "R6 zero count error", v, 32'h4);
    run_single(32'h040, 6, 1'b1);
    wait_irq("R6 misaligned irq");
    reg_read(3'd4, v);
    check(v == 32'h4, "R6 odd count error", v, 32'h4);
    check(bursts_seen == b0, "R6 no bus use on error", 32'(bursts_seen - b0), 32'd0);

    // R7: three-link chain, mixed directions
    desc_tab[1] = '{next_ptr: 32'h20, base: 32'h1F0,  bytes: 13'd16, to_dev: 1'b0, final_link: 1'b0};
    desc_tab[2] = '{next_ptr: 32'h30, base: 32'h1000, bytes: 13'd8,  to_dev: 1'b1, final_link: 1'b0};
    desc_tab[3] = '{next_ptr: 32'h0,  base: 32'h400,  bytes: 13'd12, to_dev: 1'b0, final_link: 1'b1};
    push_seg(32'h1F0, 16, 1'b0);
    push_seg(32'h1000, 8, 1'b1);
    push_seg(32'h400, 12, 1'b0);
    reg_write(3'd4, 32'h6);
    b0 = bursts_seen; f0 = fetches; i0 = irq_rises;
    reg_write(3'd3, 32'h10);
    reg_write(3'd0, 32'h5);
    wait_irq("R7 chain irq");
    check(sb.size() == 0, "R7 all links moved", 32'(sb.size()), 32'd0);
    check(fetches - f0 == 3, "R7 fetch count", 32'(fetches - f0), 32'd3);
    check(irq_rises - i0 == 1, "R7 single interrupt", 32'(irq_rises - i0), 32'd1);
    check(bursts_seen - b0 == 3, "R7 bursts per link", 32'(bursts_seen - b0), 32'd3);
    reg_read(3'd4, v);
    check(v == 32'h2, "R7 chain done status", v, 32'h2);

    // R8: second link invalid -> abort
    desc_tab[4] = '{next_ptr: 32'h50, base: 32'h300, bytes: 13'd20, to_dev: 1'b0, final_link: 1'b0};
    desc_tab[5] = '{next_ptr: 32'h60, base: 32'hFFC, bytes: 13'd8,  to_dev: 1'b0, final_link: 1'b0};
    push_seg(32'h300, 20, 1'b0);
    reg_write(3'd4, 32'h6);
    f0 = fetches; i0 = irq_rises;
    reg_write(3'd3, 32'h40);
    reg_write(3'd0, 32'h5);
    wait_irq("R8 abort irq");
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R8 first link moved", 32'(sb.size()), 32'd0);
    check(fetches - f0 == 2, "R8 fetch stops", 32'(fetches - f0), 32'd2);
    check(irq_rises - i0 == 1, "R8 one interrupt", 32'(irq_rises - i0), 32'd1);
    reg_read(3'd4, v);
    check(v == 32'h4, "R8 error not done", v, 32'h4);

    // R9/R10: busy status, writes while busy ignored
    stall_mode = 1'b1;
    push_seg(32'h500, 32, 1'b0);
    run_single(32'h500, 32, 1'b0);
    reg_read(3'd4, v);
    check(v[0] == 1'b1, "R9 busy bit during run", v, 32'h1);
    reg_write(3'd1, 32'h700);
    reg_write(3'd0, 32'h3);
    wait_irq("R10 irq after busy run");
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R10 original run only", 32'(sb.size()), 32'd0);
    reg_read(3'd1, v);
    check(v == 32'h500, "R10 base kept", v, 32'h500);
    reg_read(3'd0, v);
    check(v == 32'h0, "R10 control kept", v, 32'h0);
    stall_mode = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule